// File: doc/BRIEF.md
# Clock-synchronous serial host port

This block is the slave end of a four-wire serial link between a host and a display controller. The host pulls chip select low, clocks in a start byte, and then moves 16-bit words in either direction. The start byte has four fields. A fixed device code must match. One bit must equal a strap input, so two controllers can share one bus. A register-select bit chooses between the index register and the data path. A read flag chooses the direction.

On writes, each word goes to one of three places: the index register held inside the port, a control register (pulse `wr_reg`), or graphics memory (pulse `wr_mem`). Memory is chosen when the index holds the memory data index. On reads, the port first sends zero dummy bytes: one before status or register data, five before memory data. It then returns 16-bit words, upper byte first. Each memory word fetched for output raises `rd_next`, which steps the memory address counter.

The serial clock, chip select and data input are sampled in the system clock domain. Their edges are found there as well.

Top module: `serial_host_port`

## Requirements
- R1: A start byte whose bits [7:3] differ from 5'b01110 makes the whole transaction ignored: no write pulse, no index change, and `sdo` stays 0.
- R2: Start byte bit [2] must equal `id_sel`. On a mismatch the transaction is ignored. On a match it proceeds for either strap value.
- R3: A write with start bit [1] (register select) = 0 loads the low 8 bits of each completed word into `reg_index`.
- R4: A write with register select = 1 and `reg_index` not equal to 8'h22 gives one single-cycle `wr_reg` pulse per completed word, with `wr_data` holding the word.
- R5: A write with register select = 1 and `reg_index` = 8'h22 gives one single-cycle `wr_mem` pulse per completed word. Back-to-back words in one transaction each give their own pulse.
- R6: Start bit [0] = 1 marks a read. Data the host shifts in during a read causes no write and no index change.
- R7: A read with register select = 0 returns one 8'h00 dummy byte, then `status_in` upper byte, then lower byte.
- R8: A read with register select = 1 and index not 8'h22 returns one dummy byte, then `reg_rdata` upper then lower byte.
- R9: A read with register select = 1 and index 8'h22 returns five dummy bytes, then successive memory words. Each word is fetched from `mem_rdata` on the falling edge that starts its upper byte; that falling edge is the one ending the previous byte. Each fetch gives one `rd_next` pulse.
- R10: Raising `cs_n` aborts the transaction. A partly received word is dropped, and the next transaction's first byte is treated as a start byte.
- R11: `sdi` is sampled on rising `sclk` and `sdo` changes after falling `sclk`, most significant bit first. A word commits only after its lower byte completes.
- R12: After reset `reg_index` is 0, `sdo` is 0 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| id_sel | input | 1 | Strap value the start byte's ID bit must match |
| sdo | output | 1 | Serial data to host |
| status_in | input | 16 | Status word returned on status reads |
| reg_rdata | input | 16 | Control register selected by `reg_index` |
| mem_rdata | input | 16 | Memory word at the current address |
| reg_index | output | 8 | Index register |
| wr_data | output | 16 | Last completed write word |
| wr_reg | output | 1 | Control register write strobe |
| wr_mem | output | 1 | Memory write strobe |
| rd_next | output | 1 | Memory address step after a read fetch |

## Verification
The assertions take three things for granted. First, `sclk` stays in each level for several system clock cycles. Second, `cs_n` only changes while `sclk` is low. Third, `sdi` is steady around each rising edge. If these do not hold, edge detection in the system clock domain would miss or merge edges.

The stimulus meets all three. It moves every serial signal on the falling system clock, holds each `sclk` phase for six cycles, and toggles chip select only with the serial clock idle. After an abort, pulses and `sdo` are expected to be gone once `cs_n` has been high for three sampled cycles.

// File: rtl/serial_host_port.sv
module serial_host_port #(
  parameter logic [4:0] DEV_CODE  = 5'b01110,
  parameter logic [7:0] MEM_INDEX = 8'h22,
  parameter int unsigned MEM_DUMMY = 5,
  parameter int unsigned REG_DUMMY = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        id_sel,
  output logic        sdo,
  input  logic [15:0] status_in,
  input  logic [15:0] reg_rdata,
  input  logic [15:0] mem_rdata,
  output logic [7:0]  reg_index,
  output logic [15:0] wr_data,
  output logic        wr_reg,
  output logic        wr_mem,
  output logic        rd_next
);
  localparam logic [2:0] MD = 3'(MEM_DUMMY);
  localparam logic [2:0] RD = 3'(REG_DUMMY);

  logic [1:0] sclk_s;
  logic       cs_s, sdi_s;
  logic [2:0] bit_cnt, dummy;
  logic [7:0] rx_sh, hi, tx8, tx_lo;
  logic       started, valid, rs, rw, to_mem, lower, tx_lower;

  wire act       = ~cs_s;
  wire rise      = sclk_s[0] & ~sclk_s[1];
  wire fall      = ~sclk_s[0] & sclk_s[1];
  wire [7:0] rx_byte = {rx_sh[6:0], sdi_s};
  wire byte_done = act & rise & (bit_cnt == 3'd7);
  wire start_ok  = (rx_byte[7:3] == DEV_CODE) && (rx_byte[2] == id_sel);
  wire mem_sel   = (reg_index == MEM_INDEX);
  wire [15:0] src = !rs ? status_in : (to_mem ? mem_rdata : reg_rdata);

  assign sdo = tx8[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s <= 2'b00; cs_s <= 1'b1; sdi_s <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[0], sclk}; cs_s <= cs_n; sdi_s <= sdi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0; dummy <= '0; rx_sh <= '0; hi <= '0; tx8 <= '0; tx_lo <= '0;
      started <= 1'b0; valid <= 1'b0; rs <= 1'b0; rw <= 1'b0; to_mem <= 1'b0;
      lower <= 1'b0; tx_lower <= 1'b0;
      reg_index <= '0; wr_data <= '0; wr_reg <= 1'b0; wr_mem <= 1'b0; rd_next <= 1'b0;
    end else begin
      wr_reg <= 1'b0; wr_mem <= 1'b0; rd_next <= 1'b0;
      if (!act) begin
        bit_cnt <= '0; dummy <= '0; started <= 1'b0; valid <= 1'b0;
        lower <= 1'b0; tx_lower <= 1'b0; tx8 <= '0;
      end else begin
        if (rise) begin
          rx_sh   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          if (!started) begin
            started <= 1'b1;
            valid   <= start_ok;
            rs      <= rx_byte[1];
            rw      <= rx_byte[0];
            to_mem  <= rx_byte[1] & mem_sel;
            dummy   <= !rx_byte[0] ? 3'd0 : ((rx_byte[1] & mem_sel) ? MD : RD);
          end else if (valid && !rw) begin
            if (!lower) begin
              hi    <= rx_byte;
              lower <= 1'b1;
            end else begin
              lower   <= 1'b0;
              wr_data <= {hi, rx_byte};
              if (!rs)        reg_index <= rx_byte;
              else if (to_mem) wr_mem   <= 1'b1;
              else             wr_reg   <= 1'b1;
            end
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0 && started && valid && rw) begin
            if (dummy != 3'd0) begin
              dummy <= dummy - 3'd1;
              tx8   <= 8'h00;
            end else if (!tx_lower) begin
              tx8      <= src[15:8];
              tx_lo    <= src[7:0];
              tx_lower <= 1'b1;
              rd_next  <= to_mem;
            end else begin
              tx8      <= tx_lo;
              tx_lower <= 1'b0;
            end
          end else begin
            tx8 <= {tx8[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_host_port_chk.sv
module serial_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sdo,
  input logic       wr_reg,
  input logic       wr_mem,
  input logic       rd_next,
  input logic [7:0] reg_index
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !wr_reg && !wr_mem && !rd_next && !sdo);

  p_index_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> $stable(reg_index));

  p_reg_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reg |=> !wr_reg);

  p_mem_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mem |=> !wr_mem);

  p_fetch_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next |=> !rd_next);

  p_no_fetch_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next |-> !wr_reg && !wr_mem);
endmodule

bind serial_host_port serial_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .wr_reg(wr_reg),
  .wr_mem(wr_mem), .rd_next(rd_next), .reg_index(reg_index)
);

// File: tb/test_serial_host_port.sv
module test_serial_host_port;
  localparam int HALF = 6;
  localparam int NV = 10;
  // {start, word, kind(0 none,1 index,2 reg,3 mem), req}
  localparam logic [29:0] VEC [NV] = '{
    {8'h70, 16'h0005, 2'd1, 4'd3},   // R3 index write
    {8'h72, 16'hA5C3, 2'd2, 4'd4},   // R4 control register write
    {8'h74, 16'h1234, 2'd0, 4'd2},   // R2 ID bit mismatch
    {8'h60, 16'h0011, 2'd0, 4'd1},   // R1 wrong device code
    {8'hF2, 16'h0022, 2'd0, 4'd1},   // R1 wrong device code
    {8'h70, 16'h0022, 2'd1, 4'd3},   // R3 select memory index
    {8'h72, 16'h0F0F, 2'd3, 4'd5},   // R5 memory write
    {8'h73, 16'h5555, 2'd0, 4'd6},   // R6 read: host data ignored
    {8'h70, 16'h0009, 2'd1, 4'd3},   // R3
    {8'h72, 16'hFFFF, 2'd2, 4'd4}    // R4
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0, id_sel = 0;
  logic [15:0] status_in = 16'h0, reg_rdata = 16'h0;
  logic [15:0] mem_rdata;
  logic        sdo, wr_reg, wr_mem, rd_next;
  logic [7:0]  reg_index;
  logic [15:0] wr_data;
  int checks = 0, errors = 0;
  int n_reg = 0, n_mem = 0, n_rd = 0;
  logic [15:0] last_reg = 0, last_mem = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign mem_rdata = 16'h4000 + 16'(n_rd);

  serial_host_port i_serial_host_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .id_sel(id_sel),
    .sdo(sdo), .status_in(status_in), .reg_rdata(reg_rdata), .mem_rdata(mem_rdata),
    .reg_index(reg_index), .wr_data(wr_data), .wr_reg(wr_reg), .wr_mem(wr_mem),
    .rd_next(rd_next)
  );

  always @(negedge clk) begin
    if (wr_reg) begin n_reg++; last_reg = wr_data; end
    if (wr_mem) begin n_mem++; last_mem = wr_data; end
    if (rd_next) n_rd++;
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = sdo;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic open_tx;
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_tx;
    repeat (HALF) @(negedge clk); cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] st, input logic [15:0] w);
    logic [7:0] r;
    open_tx; xfer(st, r); xfer(w[15:8], r); xfer(w[7:0], r); close_tx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual %h expected %h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, r;
    logic [15:0] wd;
    logic [1:0] kd;
    logic [3:0] rq;
    logic [7:0] exp_idx;
    int b_reg, b_mem, b_rd;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check(reg_index == 8'h00 && !sdo && !wr_reg && !wr_mem && !rd_next, "R12",
          {reg_index, 7'b0, sdo}, 16'h0);
    exp_idx = 8'h00;

    for (int k = 0; k < NV; k++) begin
      {st, wd, kd, rq} = VEC[k];
      b_reg = n_reg; b_mem = n_mem;
      write_word(st, wd);
      if (kd == 2'd1) exp_idx = wd[7:0];
      check(reg_index == exp_idx, $sformatf("R%0d index", rq), {8'h0, reg_index}, {8'h0, exp_idx});
      check(n_reg - b_reg == (kd == 2'd2 ? 1 : 0), $sformatf("R%0d reg pulses", rq),
            16'(n_reg - b_reg), (kd == 2'd2) ? 16'd1 : 16'd0);
      check(n_mem - b_mem == (kd == 2'd3 ? 1 : 0), $sformatf("R%0d mem pulses", rq),
            16'(n_mem - b_mem), (kd == 2'd3) ? 16'd1 : 16'd0);
      if (kd == 2'd2) check(last_reg == wd, $sformatf("R%0d reg data", rq), last_reg, wd);
      if (kd == 2'd3) check(last_mem == wd, $sformatf("R%0d mem data", rq), last_mem, wd);
    end

    // R2 strap set to 1 accepts ID bit 1
    id_sel = 1;
    write_word(8'h74, 16'h0033);
    check(reg_index == 8'h33, "R2 strap high", {8'h0, reg_index}, 16'h0033);
    id_sel = 0;

    // R5 three consecutive memory words in one transaction
    write_word(8'h70, 16'h0022);
    b_mem = n_mem;
    open_tx; xfer(8'h72, r);
    xfer(8'h11, r); xfer(8'h22, r);
    xfer(8'h33, r); xfer(8'h44, r);
    xfer(8'h55, r); xfer(8'h66, r);
    close_tx;
    check(n_mem - b_mem == 3, "R5 burst count", 16'(n_mem - b_mem), 16'd3);
    check(last_mem == 16'h5566, "R5 burst last", last_mem, 16'h5566);

    // R10 abort after upper byte, then next first byte is a start byte
    write_word(8'h70, 16'h0005);
    b_reg = n_reg;
    open_tx; xfer(8'h72, r); xfer(8'hAB, r); close_tx;
    check(n_reg == b_reg, "R10 partial word dropped", 16'(n_reg - b_reg), 16'd0);
    open_tx; xfer(8'hAB, r); xfer(8'hCD, r); xfer(8'hEF, r); close_tx;
    check(n_reg == b_reg && reg_index == 8'h05, "R10 fresh start byte",
          16'(n_reg - b_reg), 16'd0);

    // R7 / R11 status read, MSB first
    status_in = 16'hC35A;
    open_tx; xfer(8'h71, r);
    xfer(8'hFF, r); check(r == 8'h00, "R7 dummy", {8'h0, r}, 16'h0000);
    xfer(8'hFF, r); check(r == 8'hC3, "R11 status upper", {8'h0, r}, 16'h00C3);
    xfer(8'hFF, r); check(r == 8'h5A, "R7 status lower", {8'h0, r}, 16'h005A);
    close_tx;
    check(sdo == 1'b0, "R10 sdo idle", {15'h0, sdo}, 16'h0);

    // R8 register read
    reg_rdata = 16'hBEEF;
    open_tx; xfer(8'h73, r);
    xfer(8'h00, r); check(r == 8'h00, "R8 dummy", {8'h0, r}, 16'h0000);
    xfer(8'h00, r); check(r == 8'hBE, "R8 upper", {8'h0, r}, 16'h00BE);
    xfer(8'h00, r); check(r == 8'hEF, "R8 lower", {8'h0, r}, 16'h00EF);
    close_tx;

    // R9 memory read: five dummies, two words, three fetches
    write_word(8'h70, 16'h0022);
    b_rd = n_rd;
    open_tx; xfer(8'h73, r);
    for (int d = 0; d < 5; d++) begin
      xfer(8'h00, r);
      check(r == 8'h00, "R9 dummy", {8'h0, r}, 16'h0000);
    end
    xfer(8'h00, r); check(r == 8'h40, "R9 word0 upper", {8'h0, r}, 16'h0040);
    xfer(8'h00, r); check(r == 8'h00, "R9 word0 lower", {8'h0, r}, 16'h0000);
    xfer(8'h00, r); check(r == 8'h40, "R9 word1 upper", {8'h0, r}, 16'h0040);
    xfer(8'h00, r); check(r == 8'h01, "R9 word1 lower", {8'h0, r}, 16'h0001);
    close_tx;
    check(n_rd - b_rd == 3, "R9 fetch pulses", 16'(n_rd - b_rd), 16'd3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule